// File: doc/BRIEF.md
# SMBus System-Interface Request Reassembler

This block sits behind an SMBus target engine that has already stripped the address, framing and checksum. Each block write arrives as a stream of bytes: a command byte, then an optional length byte, then payload. The block stores the payload of single-part and multi-part writes into a message buffer of up to 255 bytes. When a message is complete, the block presents it to the downstream management-controller port with its length and an 8-bit sequence tag. A malformed write raises a one-cycle error pulse.

One request is never forwarded. When the completed message is the application-class "get system interface capabilities" query, the block answers it locally. It writes a 3- or 7-byte reply into a small response buffer and publishes that reply's length.

Both data paths use valid/ready handshakes. An input byte transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops for one cycle after the last byte of each write, and it stays low for as long as a completed message waits on the output. A completed message is held on the output until an edge where `msg_valid` and `msg_ready` are both high. While it waits, `msg_len` and `msg_seq` do not change and the buffer cannot be written. The downstream side reads message bytes through `msg_rd_addr` while `msg_valid` is high.

Top module: `ssif_req_reasm`

## Requirements
- R1: A write with command code 0x02 and a valid length completes a message made of exactly its payload. The result appears on the output one cycle after the last byte's handshake: `msg_valid` high, `msg_len` equal to the payload count, and byte k readable at `msg_rd_addr` = k.
- R2: The second byte of a write is the length byte. It must equal the number of bytes that follow it and must not exceed 32. If it fails either test, `err` pulses and nothing is dispatched.
- R3: A write with code 0x02 or 0x06 must carry at least 2 payload bytes. A valid code 0x06 write starts a new message at offset 0 and replaces any partial message. Any rejected 0x02 or 0x06 write abandons the partial message.
- R4: A write with code 0x07 or 0x08 while no message is in progress pulses `err`.
- R5: If a 0x07 or 0x08 write would bring the total past 255 bytes, `err` pulses and the partial message is discarded.
- R6: A 0x07 write with exactly 32 payload bytes appends without completing. A 0x07 write with fewer than 32 payload bytes, including zero, completes the message, and so does any 0x08 write.
- R7: A completed message whose first byte is 0x18 and second byte is 0x57 is not dispatched. Instead `resp_len` becomes 7 and the response bytes are 0x1C, 0x57, 0x00, 0x00, 0x80, 0xFF, 0xFF.
- R8: For that query, a message shorter than 3 bytes gives a 3-byte reply 0x1C, 0x57, 0xC7. A third byte with a nonzero low nibble gives a 3-byte reply 0x1C, 0x57, 0xCC.
- R9: Dispatching a message downstream clears `resp_len` to 0.
- R10: `msg_seq` carries the expected-response counter, which is 0 after reset. The counter advances by one only when `bmc_rsp_valid` is high and `bmc_rsp_seq` equals it.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_len` and `msg_seq` hold and `in_ready` is low.
- R12: A write with any other command code and a valid length changes nothing: no error, no dispatch, and a partial message is kept.
- R13: After reset `msg_valid`, `err` and `resp_len` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a block write |
| msg_valid | output | 1 | Completed message waiting downstream |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_len | output | 8 | Byte count of the waiting message |
| msg_seq | output | 8 | Sequence tag of the waiting message |
| msg_rd_addr | input | 8 | Message buffer read address |
| msg_rd_data | output | 8 | Message byte at `msg_rd_addr` |
| bmc_rsp_valid | input | 1 | A downstream response arrived |
| bmc_rsp_seq | input | 8 | Tag of that response |
| resp_len | output | 3 | Length of the locally built reply, 0 if none |
| resp_rd_addr | input | 3 | Local reply read address |
| resp_rd_data | output | 8 | Local reply byte at `resp_rd_addr` |
| err | output | 1 | One-cycle pulse for a rejected write |

## Verification
On every cycle, the assertions check the output hold rule under back-pressure and that a dispatched length is never zero. They also check that an error never coincides with a dispatch, that a dispatch always leaves `resp_len` at zero, and that `resp_len` only takes the values 0, 3 or 7. They further check that buffer writes stay in range and that end-of-write markers never arrive back to back. Only the bench's scenarios can show that the bytes land at the right offsets across start, middle and end writes. The same holds for the exact boundary at 32 payload bytes and at 255 total bytes, the content of the locally built replies, and the matching rule of the sequence counter.

// File: rtl/ssif_rx_pkg.sv
package ssif_rx_pkg;
  typedef enum logic [7:0] {
    CMD_SINGLE = 8'h02,
    CMD_FIRST  = 8'h06,
    CMD_MID    = 8'h07,
    CMD_LAST   = 8'h08
  } wr_cmd_e;

  localparam logic [7:0] REQ_NETFN_APP = 8'h18;
  localparam logic [7:0] RSP_NETFN_APP = 8'h1C;
  localparam logic [7:0] CAP_QUERY     = 8'h57;
  localparam logic [7:0] CC_BAD_LEN    = 8'hC7;
  localparam logic [7:0] CC_BAD_FIELD  = 8'hCC;

  typedef struct packed {
    logic [7:0] cmd;
    logic       has_len;
    logic [7:0] len_byte;
    logic [7:0] cnt;
  } wr_summary_t;
endpackage

// File: rtl/ssif_frame_rx.sv
module ssif_frame_rx
  import ssif_rx_pkg::*;
#(
  parameter int CHUNK = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic [7:0]  data,
  input  logic        last,
  output logic        pay_we,
  output logic [7:0]  pay_idx,
  output logic [7:0]  pay_data,
  output logic        done,
  output wr_summary_t summ
);
  logic [7:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      done  <= 1'b0;
      summ  <= '0;
    end else begin
      done <= acc && last;
      if (acc) begin
        if (pos_q == 8'd0) begin
          summ.cmd     <= data;
          summ.has_len <= 1'b0;
          summ.cnt     <= '0;
        end else if (pos_q == 8'd1) begin
          summ.len_byte <= data;
          summ.has_len  <= 1'b1;
        end else if (summ.cnt != 8'hFF) begin
          summ.cnt <= summ.cnt + 8'd1;
        end
        if (last)                pos_q <= '0;
        else if (pos_q != 8'hFF) pos_q <= pos_q + 8'd1;
      end
    end
  end

  assign pay_we   = acc && (pos_q >= 8'd2) && (summ.cnt < 8'(CHUNK));
  assign pay_idx  = summ.cnt;
  assign pay_data = data;
endmodule

// File: rtl/ssif_msg_buf.sv
module ssif_msg_buf #(
  parameter int DEPTH = 255,
  localparam int AW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic [7:0]    hdr0,
  output logic [7:0]    hdr1,
  output logic [7:0]    hdr2
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
  assign hdr0  = mem[0];
  assign hdr1  = mem[1];
  assign hdr2  = mem[2];

  // R5: appends never reach past the buffer end
  p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < DEPTH));
endmodule

// File: rtl/ssif_cap_resp.sv
module ssif_cap_resp
  import ssif_rx_pkg::*;
#(
  parameter int MAXSZ = 255,
  localparam int LW = $clog2(MAXSZ + 1)
) (
  input  logic [LW-1:0]   req_len,
  input  logic [7:0]      req_b2,
  output logic [6:0][7:0] rbytes,
  output logic [2:0]      rlen
);
  always_comb begin
    rbytes    = '0;
    rbytes[0] = RSP_NETFN_APP;
    rbytes[1] = CAP_QUERY;
    if (int'(req_len) < 3) begin
      rbytes[2] = CC_BAD_LEN;
      rlen      = 3'd3;
    end else if (req_b2[3:0] != 4'h0) begin
      rbytes[2] = CC_BAD_FIELD;
      rlen      = 3'd3;
    end else begin
      rbytes[2] = 8'h00;
      rbytes[3] = 8'h00;
      rbytes[4] = 8'h80;
      rbytes[5] = 8'(MAXSZ);
      rbytes[6] = 8'(MAXSZ);
      rlen      = 3'd7;
    end
  end
endmodule

// File: rtl/ssif_req_reasm.sv
module ssif_req_reasm
  import ssif_rx_pkg::*;
#(
  parameter int DEPTH = 255,
  parameter int CHUNK = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [LW-1:0] msg_len,
  output logic [7:0]    msg_seq,
  input  logic [LW-1:0] msg_rd_addr,
  output logic [7:0]    msg_rd_data,
  input  logic          bmc_rsp_valid,
  input  logic [7:0]    bmc_rsp_seq,
  output logic [2:0]    resp_len,
  input  logic [2:0]    resp_rd_addr,
  output logic [7:0]    resp_rd_data,
  output logic          err
);
  logic        acc, pay_we, done;
  logic [7:0]  pay_idx, pay_data;
  wr_summary_t summ;

  logic [LW-1:0]   inlen_q, nxt_inlen;
  logic [7:0]      seq_q, hdr0, hdr1, hdr2;
  logic [6:0][7:0] resp_q, cap_bytes;
  logic [2:0]      cap_len;
  logic            is_new, is_app, len_ok, set_err, send, is_cap, buf_we;
  logic [LW:0]     sum_len, waddr_w;

  assign in_ready = !msg_valid && !done;
  assign acc      = in_valid && in_ready;

  ssif_frame_rx #(.CHUNK(CHUNK)) u_frame (
    .clk(clk), .rst_n(rst_n), .acc(acc), .data(in_data), .last(in_last),
    .pay_we(pay_we), .pay_idx(pay_idx), .pay_data(pay_data),
    .done(done), .summ(summ)
  );

  assign is_new  = (summ.cmd == CMD_SINGLE) || (summ.cmd == CMD_FIRST);
  assign is_app  = (summ.cmd == CMD_MID) || (summ.cmd == CMD_LAST);
  assign waddr_w = (is_new ? '0 : {1'b0, inlen_q}) + (LW+1)'(pay_idx);
  assign buf_we  = pay_we && (is_new || is_app) && (int'(waddr_w) < DEPTH);

  ssif_msg_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .waddr(waddr_w[LW-1:0]),
    .wdata(pay_data), .raddr(msg_rd_addr), .rdata(msg_rd_data),
    .hdr0(hdr0), .hdr1(hdr1), .hdr2(hdr2)
  );

  assign len_ok  = !summ.has_len ||
                   ((summ.len_byte == summ.cnt) && (summ.len_byte <= 8'(CHUNK)));
  assign sum_len = {1'b0, inlen_q} + (LW+1)'(summ.cnt);

  always_comb begin
    nxt_inlen = inlen_q;
    set_err   = 1'b0;
    send      = 1'b0;
    if (done) begin
      if (!len_ok) begin
        set_err = 1'b1;
        if (is_new) nxt_inlen = '0;
      end else if (is_new) begin
        if (summ.cnt < 8'd2) begin
          set_err   = 1'b1;
          nxt_inlen = '0;
        end else begin
          nxt_inlen = LW'(summ.cnt);
          send      = (summ.cmd == CMD_SINGLE);
        end
      end else if (is_app) begin
        if (inlen_q == '0) begin
          set_err = 1'b1;
        end else if (int'(sum_len) > DEPTH) begin
          set_err   = 1'b1;
          nxt_inlen = '0;
        end else begin
          nxt_inlen = sum_len[LW-1:0];
          send      = (summ.cmd == CMD_LAST) || (summ.cnt < 8'(CHUNK));
        end
      end
    end
  end

  assign is_cap = (hdr0 == REQ_NETFN_APP) && (hdr1 == CAP_QUERY);

  ssif_cap_resp #(.MAXSZ(DEPTH)) u_cap (
    .req_len(nxt_inlen), .req_b2(hdr2), .rbytes(cap_bytes), .rlen(cap_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inlen_q   <= '0;
      seq_q     <= '0;
      msg_valid <= 1'b0;
      msg_len   <= '0;
      msg_seq   <= '0;
      resp_len  <= '0;
      resp_q    <= '0;
      err       <= 1'b0;
    end else begin
      inlen_q <= nxt_inlen;
      err     <= set_err;
      if (bmc_rsp_valid && (bmc_rsp_seq == seq_q)) seq_q <= seq_q + 8'd1;
      if (msg_valid && msg_ready) msg_valid <= 1'b0;
      if (send && (nxt_inlen != '0)) begin
        if (is_cap) begin
          resp_q   <= cap_bytes;
          resp_len <= cap_len;
        end else begin
          msg_valid <= 1'b1;
          msg_len   <= nxt_inlen;
          msg_seq   <= seq_q;
          resp_len  <= '0;
        end
      end
    end
  end

  assign resp_rd_data = (resp_rd_addr < 3'd7) ? resp_q[resp_rd_addr] : 8'h00;

  // R11: a waiting message holds its length and tag
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_len) && $stable(msg_seq));
  // R1: a dispatched message is never empty
  p_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_len != '0);
  // R9: a new dispatch leaves no local reply pending
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> resp_len == 3'd0);
  // R2: a rejected write never dispatches
  p_err_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$rose(msg_valid));
  // R8: local reply lengths are 3 or 7 only
  p_resp_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_len == 3'd0 || resp_len == 3'd3 || resp_len == 3'd7);
  // R11: end-of-write markers are separated by the stall cycle
  p_done_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/ssif_req_reasm_test.sv
module ssif_req_reasm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, msg_ready = 1'b0, bmc_rsp_valid = 1'b0;
  logic [7:0] in_data = '0, bmc_rsp_seq = '0, msg_rd_addr = '0;
  logic [2:0] resp_rd_addr = '0;
  logic       in_ready, msg_valid, err;
  logic [7:0] msg_len, msg_seq, msg_rd_data, resp_rd_data;
  logic [2:0] resp_len;

  int n_chk = 0, n_fail = 0;
  logic [7:0] pay [0:63];
  logic [7:0] exp_seq = 8'd0;

  always #2.5 clk = ~clk;

  ssif_req_reasm uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_len(msg_len), .msg_seq(msg_seq),
    .msg_rd_addr(msg_rd_addr), .msg_rd_data(msg_rd_data),
    .bmc_rsp_valid(bmc_rsp_valid), .bmc_rsp_seq(bmc_rsp_seq),
    .resp_len(resp_len), .resp_rd_addr(resp_rd_addr),
    .resp_rd_data(resp_rd_data), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input bit lst);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = b; in_last = lst;
    @(posedge clk);
  endtask

  // Sends cmd [len] pay[0..n-1]; returns at the negedge where results are visible
  task automatic send_wr(input logic [7:0] cmd, input bit has_len,
                         input int lenb, input int n);
    put_byte(cmd, !has_len);
    if (has_len) begin
      put_byte(8'(lenb), n == 0);
      for (int i = 0; i < n; i++) put_byte(pay[i], i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack_msg();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic fill(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) pay[i] = base + 8'(i);
  endtask

  task automatic t_reset();
    chk(msg_valid == 0, "R13 msg_valid", msg_valid, 0);
    chk(err == 0 && resp_len == 0, "R13 err/resp_len", {err, resp_len}, 0);
    chk(in_ready == 1, "R13 in_ready", in_ready, 1);
  endtask

  task automatic t_single();
    pay[0] = 8'h2C; pay[1] = 8'h01; pay[2] = 8'hAA;
    send_wr(8'h02, 1, 3, 3);
    chk(msg_valid == 1 && err == 0, "R1 dispatch", msg_valid, 1);
    chk(msg_len == 3, "R1 length", msg_len, 3);
    chk(msg_seq == exp_seq, "R10 tag", msg_seq, exp_seq);
    msg_rd_addr = 8'd2; #1;
    chk(msg_rd_data == 8'hAA, "R1 byte 2", msg_rd_data, 8'hAA);
    repeat (3) @(negedge clk);
    chk(msg_valid == 1 && msg_len == 3, "R11 hold", msg_len, 3);
    chk(in_ready == 0, "R11 in_ready low", in_ready, 0);
    ack_msg();
    chk(msg_valid == 0, "R11 released", msg_valid, 0);
  endtask

  task automatic t_seq();
    @(negedge clk); bmc_rsp_valid = 1'b1; bmc_rsp_seq = exp_seq + 8'd5;
    @(negedge clk); bmc_rsp_valid = 1'b0;
    fill(8'h30, 2); send_wr(8'h02, 1, 2, 2);
    chk(msg_seq == exp_seq, "R10 mismatch ignored", msg_seq, exp_seq);
    ack_msg();
    bmc_rsp_valid = 1'b1; bmc_rsp_seq = exp_seq;
    @(negedge clk); bmc_rsp_valid = 1'b0;
    exp_seq = exp_seq + 8'd1;
    fill(8'h30, 2); send_wr(8'h02, 1, 2, 2);
    chk(msg_seq == exp_seq, "R10 advanced", msg_seq, exp_seq);
    ack_msg();
  endtask

  task automatic t_multi();
    fill(8'h00, 32); send_wr(8'h06, 1, 32, 32);
    chk(msg_valid == 0 && err == 0, "R3 start no dispatch", msg_valid, 0);
    fill(8'h40, 32); send_wr(8'h07, 1, 32, 32);
    chk(msg_valid == 0 && err == 0, "R6 full middle appends", msg_valid, 0);
    fill(8'h80, 5); send_wr(8'h07, 1, 5, 5);
    chk(msg_valid == 1 && msg_len == 69, "R6 short middle ends", msg_len, 69);
    msg_rd_addr = 8'd40; #1;
    chk(msg_rd_data == 8'h48, "R6 byte 40", msg_rd_data, 8'h48);
    msg_rd_addr = 8'd66; #1;
    chk(msg_rd_data == 8'h82, "R6 byte 66", msg_rd_data, 8'h82);
    ack_msg();
    fill(8'h10, 32); send_wr(8'h06, 1, 32, 32);
    fill(8'h00, 32); send_wr(8'h07, 1, 0, 0);
    chk(msg_valid == 1 && msg_len == 32, "R6 zero middle ends", msg_len, 32);
    ack_msg();
    fill(8'h10, 4); send_wr(8'h06, 1, 4, 4);
    fill(8'h60, 32); send_wr(8'h08, 1, 32, 32);
    chk(msg_valid == 1 && msg_len == 36, "R6 end write", msg_len, 36);
    msg_rd_addr = 8'd4; #1;
    chk(msg_rd_data == 8'h60, "R3 restart offset", msg_rd_data, 8'h60);
    ack_msg();
  endtask

  task automatic t_errors();
    fill(8'h01, 4); send_wr(8'h02, 1, 3, 4);
    chk(err == 1 && msg_valid == 0, "R2 length mismatch", err, 1);
    fill(8'h01, 33); send_wr(8'h02, 1, 33, 33);
    chk(err == 1 && msg_valid == 0, "R2 over 32", err, 1);
    send_wr(8'h02, 1, 1, 1);
    chk(err == 1 && msg_valid == 0, "R3 too short", err, 1);
    send_wr(8'h07, 1, 2, 2);
    chk(err == 1 && msg_valid == 0, "R4 orphan middle", err, 1);
    send_wr(8'h08, 1, 2, 2);
    chk(err == 1 && msg_valid == 0, "R4 orphan end", err, 1);
  endtask

  task automatic t_overflow();
    fill(8'h00, 32); send_wr(8'h06, 1, 32, 32);
    for (int k = 0; k < 6; k++) send_wr(8'h07, 1, 32, 32);
    chk(err == 0 && msg_valid == 0, "R5 224 bytes ok", err, 0);
    send_wr(8'h07, 1, 32, 32);
    chk(err == 1 && msg_valid == 0, "R5 past 255", err, 1);
    send_wr(8'h08, 1, 1, 1);
    chk(err == 1, "R5 discarded", err, 1);
  endtask

  task automatic t_ignore();
    pay[0] = 8'h01; pay[1] = 8'h02; send_wr(8'h06, 1, 2, 2);
    send_wr(8'h03, 0, 0, 0);
    chk(err == 0 && msg_valid == 0, "R12 no effect", err, 0);
    pay[0] = 8'h03; send_wr(8'h08, 1, 1, 1);
    chk(msg_valid == 1 && msg_len == 3, "R12 partial kept", msg_len, 3);
    ack_msg();
  endtask

  task automatic t_cap();
    logic [7:0] exp7 [0:6];
    exp7 = '{8'h1C, 8'h57, 8'h00, 8'h00, 8'h80, 8'hFF, 8'hFF};
    pay[0] = 8'h18; pay[1] = 8'h57; pay[2] = 8'h00; send_wr(8'h02, 1, 3, 3);
    chk(msg_valid == 0 && resp_len == 7, "R7 local reply", resp_len, 7);
    for (int i = 0; i < 7; i++) begin
      resp_rd_addr = 3'(i); #1;
      chk(resp_rd_data == exp7[i], "R7 reply byte", resp_rd_data, exp7[i]);
    end
    send_wr(8'h02, 1, 2, 2);
    resp_rd_addr = 3'd2; #1;
    chk(resp_len == 3 && resp_rd_data == 8'hC7, "R8 short query", resp_rd_data, 8'hC7);
    pay[2] = 8'h05; send_wr(8'h02, 1, 3, 3);
    #1;
    chk(resp_len == 3 && resp_rd_data == 8'hCC, "R8 bad field", resp_rd_data, 8'hCC);
    pay[0] = 8'h2C; send_wr(8'h02, 1, 3, 3);
    chk(msg_valid == 1 && resp_len == 0, "R9 dispatch clears", resp_len, 0);
    ack_msg();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_seq();
    t_multi();
    t_errors();
    t_overflow();
    t_ignore();
    t_cap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule